// File: doc/BRIEF.md
# Programmable Region Access Checker

This block guards a large external memory. Every request that reaches it carries an address, a domain identifier, a privileged flag, a secure flag and an access kind (read, write or execute). The block looks up the sixteen region descriptors that belong to the requesting domain. It compares the address against all of them at once and answers grant or deny one clock later. The start and inclusive end of each region are set freely by configuration, at 16 KB granularity.

Each descriptor names one of eight shared permission sets. A permission set holds a read/write/execute triple for each of the four combinations of secure state and privilege. Each descriptor also carries a valid bit and a non-secure veto bit. When the veto bit is set, any non-secure request that lands in that region is refused. A write-only configuration port programs the permission sets and the descriptor words. It is meant to be driven by trusted boot firmware.

Top module: `region_access_guard`

## Requirements
- R1: After reset, all descriptors are invalid, all permission sets are zero, and resp_valid and resp_grant are low, so every request is denied.
- R2: resp_valid is high in exactly the cycle after a cycle with req_valid high. resp_grant is never high without resp_valid.
- R3: A region contains an address when start <= addr <= end. The start is word0[31:14] followed by 14 zero bits. The end is word1[31:14] followed by 14 one bits, so both bounds are inclusive.
- R4: Descriptor word1 bit 0 is the valid bit. A region whose valid bit is clear never contributes a grant.
- R5: A permission set is a 16-bit value. The group for secure privileged sits at bits 14:12, secure user at 10:8, non-secure privileged at 6:4 and non-secure user at 2:0. Within a group, the top bit is read, the middle bit is write and the low bit is execute. Descriptor word0 bits 2:0 select the set.
- R6: Descriptor word1 bit 4 is the non-secure veto. When it is set, a request with req_secure low is denied by that region, even if the permission set allows it.
- R7: A request whose address lies in no valid region of its domain is denied.
- R8: When several valid regions contain the address, the request is granted if any one of them allows it.
- R9: Only the descriptors of the requesting domain (req_did) are considered.
- R10: req_kind encodes 00 read, 01 write and 10 execute. The code 11 is always denied.
- R11: Configuration writes use cfg_addr. With bit 9 low, bits 2:0 pick a permission set and cfg_wdata[15:0] is stored. With bit 9 high, bits 8:5 pick the domain, bits 4:1 the region and bit 0 the descriptor word. A write is seen by a request presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_did | input | 4 | Requesting domain identifier |
| req_priv | input | 1 | Request is privileged |
| req_secure | input | 1 | Request is secure |
| req_kind | input | 2 | Access kind |
| resp_valid | output | 1 | Verdict present |
| resp_grant | output | 1 | Access granted when high |

## Verification
The verdict for a request driven in one cycle is due on resp_valid and resp_grant after exactly one rising edge. The bench drives each request on a falling edge and samples the verdict on the next falling edge. A configuration write is driven on a falling edge and lands on the following rising edge. A request driven on the falling edge after that must already see the new state, and the bench checks this directly. After each request the bench also checks an idle cycle, to confirm that resp_valid drops again one edge after req_valid falls.

// File: rtl/rag_pkg.sv
// Shared types and helpers for the region access guard.
// Assumes 12-bit compacted permission sets: group g at bits 3g+2..3g,
// g = {secure, privileged}; bit 2 read, bit 1 write, bit 0 execute.
package rag_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_EXEC  = 2'b10,
        KIND_RSV   = 2'b11
    } access_kind_e;

    localparam int PERM_W   = 12;
    localparam int NSV_BIT  = 4;
    localparam int VLD_BIT  = 0;

    // Decide whether a compacted permission set allows one access.
    function automatic logic perm_allows(input logic [PERM_W-1:0] p,
                                         input logic sec, input logic priv,
                                         input logic [1:0] kind);
        logic [2:0] grp;
        grp = p[3*{sec, priv} +: 3];
        case (kind)
            KIND_READ:  return grp[2];
            KIND_WRITE: return grp[1];
            KIND_EXEC:  return grp[0];
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rag_perm_bank.sv
// Holds the shared permission sets. Each set is written as 16 bits
// (four 3-bit groups on 4-bit spacing) and stored compacted to 12 bits.
// Assumes the writer aligns wr_idx with a legal set index.
module rag_perm_bank #(
    parameter int NUM_SETS = 8,
    localparam int SEL_W   = $clog2(NUM_SETS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [SEL_W-1:0]                      wr_idx,
    input  logic [15:0]                           wr_data,
    output logic [NUM_SETS-1:0][rag_pkg::PERM_W-1:0] sets
);
    logic unused_gap_bits;
    assign unused_gap_bits = ^{wr_data[15], wr_data[11], wr_data[7], wr_data[3]};

    // Store a compacted set on write; clear all sets on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sets <= '0;
        end else if (wr_en) begin
            sets[wr_idx] <= {wr_data[14:12], wr_data[10:8], wr_data[6:4], wr_data[2:0]};
        end
    end
endmodule

// File: rtl/rag_desc_bank.sv
// Region descriptor storage for every domain, and a read mux that presents
// the descriptors of one domain. Word 0 carries start and set select,
// word 1 carries end, veto and valid bits.
module rag_desc_bank #(
    parameter int NUM_DOM  = 16,
    parameter int NUM_RGN  = 16,
    parameter int ADDR_W   = 32,
    parameter int GRAN_W   = 14,
    parameter int SEL_W    = 3,
    localparam int DID_W   = $clog2(NUM_DOM),
    localparam int RGN_W   = $clog2(NUM_RGN),
    localparam int BND_W   = ADDR_W - GRAN_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [DID_W-1:0]                  wr_dom,
    input  logic [RGN_W-1:0]                  wr_rgn,
    input  logic                              wr_word,
    input  logic [ADDR_W-1:0]                 wr_data,
    input  logic [DID_W-1:0]                  rd_dom,
    output logic [NUM_RGN-1:0][BND_W-1:0]     rgn_start,
    output logic [NUM_RGN-1:0][BND_W-1:0]     rgn_end,
    output logic [NUM_RGN-1:0][SEL_W-1:0]     rgn_sel,
    output logic [NUM_RGN-1:0]                rgn_nsv,
    output logic [NUM_RGN-1:0]                rgn_vld
);
    logic [BND_W-1:0] start_q [NUM_DOM][NUM_RGN];
    logic [BND_W-1:0] end_q   [NUM_DOM][NUM_RGN];
    logic [SEL_W-1:0] sel_q   [NUM_DOM][NUM_RGN];
    logic             nsv_q   [NUM_DOM][NUM_RGN];
    logic             vld_q   [NUM_DOM][NUM_RGN];

    logic unused_mid_bits;
    assign unused_mid_bits = ^wr_data[GRAN_W-1:SEL_W];

    // Reset all descriptors to invalid; update one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DOM; d++) begin
                for (int r = 0; r < NUM_RGN; r++) begin
                    start_q[d][r] <= '0;
                    end_q[d][r]   <= '0;
                    sel_q[d][r]   <= '0;
                    nsv_q[d][r]   <= 1'b0;
                    vld_q[d][r]   <= 1'b0;
                end
            end
        end else if (wr_en) begin
            if (!wr_word) begin
                start_q[wr_dom][wr_rgn] <= wr_data[ADDR_W-1:GRAN_W];
                sel_q[wr_dom][wr_rgn]   <= wr_data[SEL_W-1:0];
            end else begin
                end_q[wr_dom][wr_rgn]   <= wr_data[ADDR_W-1:GRAN_W];
                nsv_q[wr_dom][wr_rgn]   <= wr_data[rag_pkg::NSV_BIT];
                vld_q[wr_dom][wr_rgn]   <= wr_data[rag_pkg::VLD_BIT];
            end
        end
    end

    // Present the selected domain's descriptors.
    always_comb begin
        for (int r = 0; r < NUM_RGN; r++) begin
            rgn_start[r] = start_q[rd_dom][r];
            rgn_end[r]   = end_q[rd_dom][r];
            rgn_sel[r]   = sel_q[rd_dom][r];
            rgn_nsv[r]   = nsv_q[rd_dom][r];
            rgn_vld[r]   = vld_q[rd_dom][r];
        end
    end
endmodule

// File: rtl/rag_region_match.sv
// Parallel compare of one address against every region of a domain.
// Produces a hit per region and an allow per region that folds in the
// selected permission set and the non-secure veto. Purely combinational.
module rag_region_match #(
    parameter int NUM_RGN  = 16,
    parameter int ADDR_W   = 32,
    parameter int GRAN_W   = 14,
    parameter int NUM_SETS = 8,
    localparam int SEL_W   = $clog2(NUM_SETS),
    localparam int BND_W   = ADDR_W - GRAN_W
) (
    input  logic [NUM_RGN-1:0][BND_W-1:0]          rgn_start,
    input  logic [NUM_RGN-1:0][BND_W-1:0]          rgn_end,
    input  logic [NUM_RGN-1:0][SEL_W-1:0]          rgn_sel,
    input  logic [NUM_RGN-1:0]                     rgn_nsv,
    input  logic [NUM_RGN-1:0]                     rgn_vld,
    input  logic [NUM_SETS-1:0][rag_pkg::PERM_W-1:0] sets,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic                                   priv,
    input  logic                                   sec,
    input  logic [1:0]                             kind,
    output logic [NUM_RGN-1:0]                     hit_vec,
    output logic [NUM_RGN-1:0]                     allow_vec
);
    logic [BND_W-1:0] addr_g;
    logic unused_low_addr;
    assign addr_g          = addr[ADDR_W-1:GRAN_W];
    assign unused_low_addr = ^addr[GRAN_W-1:0];

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
        // Inclusive bound compare at granule level, then permission and veto.
        always_comb begin
            hit_vec[r]   = rgn_vld[r] && (addr_g >= rgn_start[r]) && (addr_g <= rgn_end[r]);
            allow_vec[r] = hit_vec[r]
                        && rag_pkg::perm_allows(sets[rgn_sel[r]], sec, priv, kind)
                        && !(rgn_nsv[r] && !sec);
        end
    end
endmodule

// File: rtl/region_access_guard.sv
// Top of the region access guard. Decodes configuration writes, holds
// permission sets and per-domain region descriptors, and returns a
// registered grant/deny one clock after each request.
// Assumes cfg_addr bit 9 picks descriptor space, and that the data word
// width equals the address width.
module region_access_guard #(
    parameter int ADDR_W   = 32,
    parameter int DID_W    = 4,
    parameter int RGN_W    = 4,
    parameter int NUM_SETS = 8,
    parameter int GRAN_W   = 14,
    localparam int NUM_DOM = 1 << DID_W,
    localparam int NUM_RGN = 1 << RGN_W,
    localparam int SEL_W   = $clog2(NUM_SETS),
    localparam int BND_W   = ADDR_W - GRAN_W,
    localparam int CFG_AW  = 2 + DID_W + RGN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DID_W-1:0]  req_did,
    input  logic              req_priv,
    input  logic              req_secure,
    input  logic [1:0]        req_kind,
    output logic              resp_valid,
    output logic              resp_grant
);
    import rag_pkg::*;

    logic                                 perm_we, desc_we;
    logic [NUM_SETS-1:0][PERM_W-1:0]      sets;
    logic [NUM_RGN-1:0][BND_W-1:0]        rgn_start, rgn_end;
    logic [NUM_RGN-1:0][SEL_W-1:0]        rgn_sel;
    logic [NUM_RGN-1:0]                   rgn_nsv, rgn_vld;
    logic [NUM_RGN-1:0]                   hit_vec, allow_vec;
    logic unused_cfg_bits;

    // Split configuration writes between the two storage banks.
    assign perm_we         = cfg_we && !cfg_addr[CFG_AW-1];
    assign desc_we         = cfg_we &&  cfg_addr[CFG_AW-1];
    assign unused_cfg_bits = ^cfg_addr[CFG_AW-2:SEL_W];

    rag_perm_bank #(.NUM_SETS(NUM_SETS)) u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (perm_we),
        .wr_idx  (cfg_addr[SEL_W-1:0]),
        .wr_data (cfg_wdata[15:0]),
        .sets    (sets)
    );

    rag_desc_bank #(
        .NUM_DOM(NUM_DOM), .NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W),
        .GRAN_W(GRAN_W), .SEL_W(SEL_W)
    ) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (desc_we),
        .wr_dom    (cfg_addr[RGN_W+DID_W:RGN_W+1]),
        .wr_rgn    (cfg_addr[RGN_W:1]),
        .wr_word   (cfg_addr[0]),
        .wr_data   (cfg_wdata),
        .rd_dom    (req_did),
        .rgn_start (rgn_start),
        .rgn_end   (rgn_end),
        .rgn_sel   (rgn_sel),
        .rgn_nsv   (rgn_nsv),
        .rgn_vld   (rgn_vld)
    );

    rag_region_match #(
        .NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .NUM_SETS(NUM_SETS)
    ) u_match (
        .rgn_start (rgn_start),
        .rgn_end   (rgn_end),
        .rgn_sel   (rgn_sel),
        .rgn_nsv   (rgn_nsv),
        .rgn_vld   (rgn_vld),
        .sets      (sets),
        .addr      (req_addr),
        .priv      (req_priv),
        .sec       (req_secure),
        .kind      (req_kind),
        .hit_vec   (hit_vec),
        .allow_vec (allow_vec)
    );

    // Register the verdict one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= req_valid && (|allow_vec);
        end
    end

    // R2: a verdict follows every request after one edge
    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R2: no verdict without a request the cycle before
    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R7: a grant needs a region hit on the request cycle
    assert_grant_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_grant |-> $past(|hit_vec));
    // R10: the reserved kind never yields a grant
    assert_rsv_denied_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_grant |-> ($past(req_kind) != KIND_RSV));
    // R4: a region only allows where it also hits
    assert_allow_within_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_vec & ~hit_vec) == '0);
endmodule

// File: tb/tb_region_access_guard.sv
`timescale 1ns/1ps
module tb_region_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_did = '0;
    logic        req_priv = 1'b0;
    logic        req_secure = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        resp_valid, resp_grant;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_perm [8];
    logic [31:0] m_w0 [16][16];
    logic [31:0] m_w1 [16][16];

    always #2.5 clk = ~clk;

    region_access_guard dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_did(req_did), .req_priv(req_priv), .req_secure(req_secure),
        .req_kind(req_kind), .resp_valid(resp_valid), .resp_grant(resp_grant)
    );

    // Reference verdict computed from the requirements.
    function automatic logic model(input logic [31:0] a, input logic [3:0] d,
                                   input logic pv, input logic sc, input logic [1:0] k);
        logic g = 1'b0;
        for (int r = 0; r < 16; r++) begin
            logic [31:0] st, en;
            logic [15:0] p;
            logic ok;
            int base;
            st = {m_w0[d][r][31:14], 14'h0};
            en = {m_w1[d][r][31:14], 14'h3FFF};
            p  = m_perm[m_w0[d][r][2:0]];
            base = 4 * {sc, pv};
            case (k)
                2'b00: ok = p[base+2];
                2'b01: ok = p[base+1];
                2'b10: ok = p[base];
                default: ok = 1'b0;
            endcase
            if (m_w1[d][r][0] && a >= st && a <= en && ok && !(m_w1[d][r][4] && !sc))
                g = 1'b1;
        end
        return g;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr_perm(input int idx, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {1'b0, 6'd0, idx[2:0]}; cfg_wdata = {16'h0, v};
        m_perm[idx] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_desc(input int d, input int r, input bit w, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {1'b1, d[3:0], r[3:0], w}; cfg_wdata = v;
        if (w) m_w1[d][r] = v; else m_w0[d][r] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request on a falling edge; verdict is due one rising edge later.
    task automatic req(input string tag, input logic [31:0] a, input int d,
                       input logic pv, input logic sc, input logic [1:0] k);
        logic exp;
        req_valid = 1'b1; req_addr = a; req_did = d[3:0];
        req_priv = pv; req_secure = sc; req_kind = k;
        exp = model(a, d[3:0], pv, sc, k);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, resp_valid, 1'b1);
        check(tag, resp_grant, exp);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        check({tag, " R2 idle valid"}, resp_valid, 1'b0);
        check({tag, " R2 idle grant"}, resp_grant, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_perm[i] = '0;
        for (int d = 0; d < 16; d++)
            for (int r = 0; r < 16; r++) begin m_w0[d][r] = '0; m_w1[d][r] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and an unprogrammed request
        check("R1 resp_valid after reset", resp_valid, 1'b0);
        check("R1 resp_grant after reset", resp_grant, 1'b0);
        req("R1 request after reset denied", 32'h8000_0000, 3, 1, 1, 2'b00);

        // R11 R5 R3: secure-only set 0, domain 3 region 0 at 0x80000000..0x9FFFFFFF
        wr_perm(0, 16'h7700);
        wr_desc(3, 0, 0, 32'h8000_0000);
        wr_desc(3, 0, 1, 32'h9FFF_C011);
        req("R11 write seen next cycle / R3 start", 32'h8000_0000, 3, 1, 1, 2'b00);
        idle("after start");
        req("R3 inclusive end", 32'h9FFF_FFFF, 3, 1, 1, 2'b01);
        req("R7 above end", 32'hA000_0000, 3, 1, 1, 2'b00);
        req("R7 below start", 32'h7FFF_FFFF, 3, 1, 1, 2'b00);
        req("R5 secure user exec", 32'h9000_0000, 3, 0, 1, 2'b10);
        req("R5 non-secure priv read", 32'h9000_0000, 3, 1, 0, 2'b00);
        req("R10 reserved kind", 32'h9000_0000, 3, 1, 1, 2'b11);
        req("R9 other domain", 32'h9000_0000, 4, 1, 1, 2'b00);

        // R6: veto on region with an all-open set
        wr_perm(2, 16'h7777);
        wr_desc(3, 1, 0, 32'hC000_0002);
        wr_desc(3, 1, 1, 32'hC000_0011);
        req("R6 veto blocks non-secure", 32'hC000_1000, 3, 0, 0, 2'b00);
        req("R3 16KB end granule", 32'hC000_4000, 3, 1, 1, 2'b00);
        wr_desc(3, 1, 1, 32'hC000_0001);
        req("R6 no veto allows non-secure", 32'hC000_3FFF, 3, 0, 0, 2'b00);
        // R4: clearing the valid bit
        wr_desc(3, 1, 1, 32'hC000_0000);
        req("R4 invalid region denied", 32'hC000_1000, 3, 1, 1, 2'b00);

        // R8: overlap, narrow read-only region plus an open one
        wr_perm(1, 16'h0004);
        wr_desc(5, 0, 0, 32'h1000_0001);
        wr_desc(5, 0, 1, 32'h1000_0001);
        wr_desc(5, 7, 0, 32'h1000_0002);
        wr_desc(5, 7, 1, 32'h1000_0001);
        req("R8 overlap any allows", 32'h1000_0100, 5, 1, 0, 2'b01);
        wr_desc(5, 7, 1, 32'h1000_0000);
        req("R8 only read-only left write", 32'h1000_0100, 5, 1, 0, 2'b01);
        req("R8 only read-only left NSU read", 32'h1000_0100, 5, 0, 0, 2'b00);

        // Random mix over domains 0..3
        for (int it = 0; it < 600; it++) begin
            if (($urandom % 10) < 3) begin
                int sg;
                sg = $urandom % 16;
                case ($urandom % 3)
                    0: wr_perm($urandom % 8, 16'($urandom) & 16'h7777);
                    1: wr_desc($urandom % 4, $urandom % 16, 0,
                               32'h8000_0000 | (32'(sg) << 14) | ($urandom % 8));
                    default: wr_desc($urandom % 4, $urandom % 16, 1,
                               32'h8000_0000 | (32'(sg + ($urandom % 4)) << 14)
                               | (32'($urandom % 2) << 4) | 32'($urandom % 4 != 0));
                endcase
                @(negedge clk);
            end else begin
                req("R3 R5 R8 random", 32'h8000_0000 | ($urandom % 32'h5_0000),
                    $urandom % 4, 1'($urandom), 1'($urandom), 2'($urandom));
            end
        end
        idle("end");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule